// File: doc/BRIEF.md
# Flash Control Registers and Address Bank Mapper

This block sits between an 8-bit CPU core and an embedded flash array. It holds two small registers on a CPU register bus. The control register carries a 4-bit key that unlocks flash command sequences and a bank bit. The standby register carries one bit that asks the flash to enter its low-current state. The bank bit steers how 16-bit CPU memory addresses become flash array addresses.

In normal (MCU) mode the flash is seen at its own addresses and the bank bit is ignored. In serial-programming mode, a 2 KB boot ROM is overlaid just below the upper half of the map. The upper half then shows either the lower flash region (shifted down by 8000h) or the upper flash region (unshifted), as chosen by the bank bit.

The standby bit clears itself when an interrupt is accepted, when the flash is accessed, or while the core sits in a low-power mode. During a low-power mode the standby request to the flash is held high whatever the bit holds. The flash array and its command sequencer live outside this block.

Top module: `flash_bank_ctl`

## Requirements
- R1: After reset the control register reads C8h (key 1100b, bank 1, bits 2..0 zero). The standby register reads 00h, and cmd_enable and flash_standby are 0.
- R2: cmd_enable is 1 exactly when the key field (control register bits 7..4) holds 0011b. Every other code, including all reserved codes, gives 0. The output follows the register in the cycle after the write.
- R3: The control register is at register address 2 and the standby register at address 3. Bit 3 of the control register is the bank bit, bits 2..0 always read 0, and standby bits 7..1 read 0. reg_rdata is 0 when reg_rd is low.
- R4: With serial_mode low, an access (mem_rd or mem_wr high) to 1000h..FFFFh asserts flash_sel with flash_addr equal to mem_addr, whatever the bank bit. An access below 1000h, or a cycle with no strobe, selects nothing.
- R5: With serial_mode high, an access to 7800h..7FFFh asserts boot_sel and not flash_sel. flash_sel and boot_sel are never both high.
- R6: With serial_mode high and bank 0, an access to 9000h..FFFFh asserts flash_sel with flash_addr = mem_addr - 8000h. Accesses to 8000h..8FFFh, or below 7800h, select nothing.
- R7: With serial_mode high and bank 1, an access to 8000h..FFFFh asserts flash_sel with flash_addr equal to mem_addr.
- R8: Writing 1 to standby bit 0 sets the bit, and flash_standby is high from the next cycle on.
- R9: An irq_ack pulse clears the standby bit at the next clock edge.
- R10: A cycle with flash_sel high clears the standby bit. A boot ROM access does not.
- R11: While lp_mode is high, the standby bit clears and flash_standby is held at 1. When lp_mode falls, flash_standby follows the (now clear) bit.
- R12: A hardware clear (irq_ack, lp_mode or flash access) wins over a software write of 1 to the standby bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | REG_AW (4) | Register bus address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Register read data, combinational |
| mem_addr | input | ADDR_W (16) | CPU memory access address |
| mem_rd | input | 1 | CPU memory read strobe |
| mem_wr | input | 1 | CPU memory write strobe |
| serial_mode | input | 1 | 1 = serial-programming mode, 0 = MCU mode |
| irq_ack | input | 1 | Interrupt accepted pulse |
| lp_mode | input | 1 | High while the core is in idle, sleep or stop |
| flash_sel | output | 1 | Access targets the flash array |
| boot_sel | output | 1 | Access targets the boot ROM |
| flash_addr | output | ADDR_W (16) | Flash array address, 0 when not selected |
| cmd_enable | output | 1 | Flash command sequences allowed |
| flash_standby | output | 1 | Standby request to the flash |

## Verification
The bench builds the block with its defaults: 16-bit addresses, a 4-bit register address with control at 2 and standby at 3, flash from 1000h, boot ROM at 7800h..7FFFh and the bank window at 8000h. These values bring every window edge within reach of a short address table: 0FFFh/1000h, 77FFh/7800h, 7FFFh/8000h, 8FFFh/9000h and FFFFh. They also keep all sixteen key codes cheap to sweep. With 4-bit register addresses, the two register locations and one unused location can be driven directly.

// File: rtl/flash_bank_pkg.sv
package flash_bank_pkg;

    localparam int REG_DW = 8;

    localparam logic [3:0] KEY_LOCK = 4'b1100;
    localparam logic [3:0] KEY_OPEN = 4'b0011;

    typedef struct packed {
        logic [3:0] key;
        logic       bank;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        logic  stby;
    } regs_t;

    localparam regs_t REGS_RESET = '{ctrl: '{key: KEY_LOCK, bank: 1'b1}, stby: 1'b0};

endpackage

// File: rtl/flash_bank_regs.sv
module flash_bank_regs
    import flash_bank_pkg::*;
#(
    parameter int                REG_AW    = 4,
    parameter logic [REG_AW-1:0] CTRL_ADDR = 4'h2,
    parameter logic [REG_AW-1:0] STBY_ADDR = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              hw_clr,
    output logic [REG_DW-1:0] reg_rdata,
    output logic [3:0]        key_o,
    output logic              bank_o,
    output logic              stby_o
);

    regs_t regs_d, regs_q;

    logic wr_ctrl, wr_stby;
    assign wr_ctrl = reg_wr && (reg_addr == CTRL_ADDR);
    assign wr_stby = reg_wr && (reg_addr == STBY_ADDR);

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.ctrl.key  = reg_wdata[7:4];
            regs_d.ctrl.bank = reg_wdata[3];
        end
        if (wr_stby) begin
            regs_d.stby = reg_wdata[0];
        end
        // hardware events override software in the same cycle
        if (hw_clr) begin
            regs_d.stby = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RESET;
        else        regs_q <= regs_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == CTRL_ADDR)      reg_rdata = {regs_q.ctrl.key, regs_q.ctrl.bank, 3'b000};
            else if (reg_addr == STBY_ADDR) reg_rdata = {7'b0, regs_q.stby};
        end
    end

    assign key_o  = regs_q.ctrl.key;
    assign bank_o = regs_q.ctrl.bank;
    assign stby_o = regs_q.stby;

    assert_hw_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr |=> !stby_o);

    assert_stby_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stby && reg_wdata[0] && !hw_clr) |=> stby_o);

    assert_key_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(key_o));

endmodule

// File: rtl/flash_bank_map.sv
module flash_bank_map #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] FLASH_LO = 16'h1000,
    parameter logic [ADDR_W-1:0] BOOT_LO  = 16'h7800,
    parameter logic [ADDR_W-1:0] BOOT_HI  = 16'h7FFF,
    parameter logic [ADDR_W-1:0] WIN_LO   = 16'h8000
) (
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              access,
    input  logic              serial_mode,
    input  logic              bank,
    output logic              flash_sel,
    output logic              boot_sel,
    output logic [ADDR_W-1:0] flash_addr
);

    // lowest CPU address of the shifted lower-flash window
    localparam logic [ADDR_W-1:0] BANK0_LO = FLASH_LO + WIN_LO;

    logic in_boot, in_upper, in_bank0;

    assign in_boot  = (mem_addr >= BOOT_LO) && (mem_addr <= BOOT_HI);
    assign in_upper = (mem_addr >= WIN_LO);
    assign in_bank0 = (mem_addr >= BANK0_LO);

    always_comb begin
        flash_sel  = 1'b0;
        boot_sel   = 1'b0;
        flash_addr = '0;
        if (access) begin
            if (!serial_mode) begin
                if (mem_addr >= FLASH_LO) begin
                    flash_sel  = 1'b1;
                    flash_addr = mem_addr;
                end
            end else if (in_boot) begin
                boot_sel = 1'b1;
            end else if (bank) begin
                if (in_upper) begin
                    flash_sel  = 1'b1;
                    flash_addr = mem_addr;
                end
            end else if (in_bank0) begin
                flash_sel  = 1'b1;
                flash_addr = mem_addr - WIN_LO;
            end
        end
    end

endmodule

// File: rtl/flash_bank_ctl.sv
module flash_bank_ctl
    import flash_bank_pkg::*;
#(
    parameter int                REG_AW    = 4,
    parameter logic [REG_AW-1:0] CTRL_ADDR = 4'h2,
    parameter logic [REG_AW-1:0] STBY_ADDR = 4'h3,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] FLASH_LO  = 16'h1000,
    parameter logic [ADDR_W-1:0] BOOT_LO   = 16'h7800,
    parameter logic [ADDR_W-1:0] BOOT_HI   = 16'h7FFF,
    parameter logic [ADDR_W-1:0] WIN_LO    = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              serial_mode,
    input  logic              irq_ack,
    input  logic              lp_mode,
    output logic              flash_sel,
    output logic              boot_sel,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              cmd_enable,
    output logic              flash_standby
);

    logic [3:0] key;
    logic       bank;
    logic       stby;
    logic       hw_clr;

    assign hw_clr = irq_ack | lp_mode | flash_sel;

    flash_bank_regs #(
        .REG_AW   (REG_AW),
        .CTRL_ADDR(CTRL_ADDR),
        .STBY_ADDR(STBY_ADDR)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .hw_clr   (hw_clr),
        .reg_rdata(reg_rdata),
        .key_o    (key),
        .bank_o   (bank),
        .stby_o   (stby)
    );

    flash_bank_map #(
        .ADDR_W  (ADDR_W),
        .FLASH_LO(FLASH_LO),
        .BOOT_LO (BOOT_LO),
        .BOOT_HI (BOOT_HI),
        .WIN_LO  (WIN_LO)
    ) map_i (
        .mem_addr   (mem_addr),
        .access     (mem_rd | mem_wr),
        .serial_mode(serial_mode),
        .bank       (bank),
        .flash_sel  (flash_sel),
        .boot_sel   (boot_sel),
        .flash_addr (flash_addr)
    );

    // reserved key codes count as locked
    assign cmd_enable    = (key == KEY_OPEN);
    assign flash_standby = stby | lp_mode;

    assert_open_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == CTRL_ADDR && reg_wdata[7:4] == KEY_OPEN) |=> cmd_enable);

    assert_other_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == CTRL_ADDR && reg_wdata[7:4] != KEY_OPEN) |=> !cmd_enable);

    assert_lp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lp_mode |-> flash_standby);

    assert_sel_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_sel && boot_sel));

    assert_mcu_ident_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && flash_sel) |-> (flash_addr == mem_addr));

    assert_bank1_ident_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && bank && flash_sel) |-> (flash_addr == mem_addr));

    assert_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd || mem_wr) |-> !(flash_sel || boot_sel));

endmodule

// File: tb/flash_bank_ctl_tb_top.sv
`timescale 1ns/1ps
module flash_bank_ctl_tb_top;

    localparam real CLK_P = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] mem_addr = '0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic        serial_mode = 1'b0;
    logic        irq_ack = 1'b0;
    logic        lp_mode = 1'b0;
    logic        flash_sel, boot_sel, cmd_enable, flash_standby;
    logic [15:0] flash_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    flash_bank_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .serial_mode(serial_mode), .irq_ack(irq_ack), .lp_mode(lp_mode),
        .flash_sel(flash_sel), .boot_sel(boot_sel), .flash_addr(flash_addr),
        .cmd_enable(cmd_enable), .flash_standby(flash_standby)
    );

    // {serial, bank, cpu addr, exp flash_sel, exp boot_sel, exp flash addr}
    localparam int NV = 17;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h0FFF, 1'b0, 1'b0, 16'h0000},
        {1'b0, 1'b0, 16'h1000, 1'b1, 1'b0, 16'h1000},
        {1'b0, 1'b1, 16'h7900, 1'b1, 1'b0, 16'h7900},
        {1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b0, 16'hFFFF},
        {1'b0, 1'b1, 16'h8500, 1'b1, 1'b0, 16'h8500},
        {1'b1, 1'b0, 16'h77FF, 1'b0, 1'b0, 16'h0000},
        {1'b1, 1'b0, 16'h7800, 1'b0, 1'b1, 16'h0000},
        {1'b1, 1'b0, 16'h7FFF, 1'b0, 1'b1, 16'h0000},
        {1'b1, 1'b0, 16'h8000, 1'b0, 1'b0, 16'h0000},
        {1'b1, 1'b0, 16'h8FFF, 1'b0, 1'b0, 16'h0000},
        {1'b1, 1'b0, 16'h9000, 1'b1, 1'b0, 16'h1000},
        {1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0, 16'h7FFF},
        {1'b1, 1'b1, 16'h7A00, 1'b0, 1'b1, 16'h0000},
        {1'b1, 1'b1, 16'h8000, 1'b1, 1'b0, 16'h8000},
        {1'b1, 1'b1, 16'hC123, 1'b1, 1'b0, 16'hC123},
        {1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b0, 16'hFFFF},
        {1'b1, 1'b1, 16'h4000, 1'b0, 1'b0, 16'h0000}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        #(CLK_P * 3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(4'h2, rd);  chk("R1", "ctrl reset", rd, 8'hC8);
        reg_read(4'h3, rd);  chk("R1", "stby reset", rd, 8'h00);
        chk("R1", "cmd_enable reset", cmd_enable, 0);
        chk("R1", "standby reset", flash_standby, 0);

        // R3 read strobe gating and unused address
        reg_addr = 4'h2; reg_rd = 1'b0;
        #1 chk("R3", "rdata without rd", reg_rdata, 0);
        reg_read(4'h5, rd);  chk("R3", "unused address", rd, 0);

        // R2 sweep all key codes; R3 low bits read zero
        for (int k = 0; k < 16; k++) begin
            reg_write(4'h2, {k[3:0], 1'b1, 3'b111});
            #1 chk("R2", $sformatf("cmd_enable key %0d", k), cmd_enable, (k == 3) ? 1 : 0);
            reg_read(4'h2, rd);
            chk("R3", $sformatf("ctrl readback key %0d", k), rd, {k[3:0], 4'b1000});
        end
        reg_write(4'h2, 8'hC8);

        // R4..R7 address table
        for (int i = 0; i < NV; i++) begin
            reg_write(4'h2, {4'b1100, VEC[i][34], 3'b000});
            @(negedge clk);
            serial_mode = VEC[i][35];
            mem_addr = VEC[i][33:18];
            mem_rd = 1'b1;
            #1;
            chk(VEC[i][35] ? (VEC[i][34] ? "R7" : "R6") : "R4",
                $sformatf("flash_sel @%h", VEC[i][33:18]), flash_sel, VEC[i][17]);
            chk("R5", $sformatf("boot_sel @%h", VEC[i][33:18]), boot_sel, VEC[i][16]);
            chk(VEC[i][35] ? (VEC[i][34] ? "R7" : "R6") : "R4",
                $sformatf("flash_addr @%h", VEC[i][33:18]), flash_addr, VEC[i][15:0]);
            @(negedge clk);
            mem_rd = 1'b0;
        end

        // R4 write strobe also selects, no strobe selects nothing
        serial_mode = 1'b0; mem_addr = 16'h2000; mem_wr = 1'b1;
        #1 chk("R4", "write strobe sel", flash_sel, 1);
        mem_wr = 1'b0;
        #1 chk("R4", "no strobe sel", flash_sel, 0);

        // R8 set standby
        reg_write(4'h3, 8'hFF);
        #1 chk("R8", "standby after set", flash_standby, 1);
        reg_read(4'h3, rd); chk("R8", "stby readback", rd, 8'h01);

        // R9 interrupt clears
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        #1 chk("R9", "standby after irq", flash_standby, 0);

        // R10 boot access keeps, flash access clears
        reg_write(4'h3, 8'h01);
        serial_mode = 1'b1; mem_addr = 16'h7C00; mem_rd = 1'b1;
        @(negedge clk); mem_rd = 1'b0;
        #1 chk("R10", "standby after boot access", flash_standby, 1);
        mem_addr = 16'hA000; mem_rd = 1'b1;
        @(negedge clk); mem_rd = 1'b0;
        #1 chk("R10", "standby after flash access", flash_standby, 0);

        // R11 low-power mode
        reg_write(4'h3, 8'h01);
        lp_mode = 1'b1;
        @(negedge clk);
        #1 chk("R11", "standby held in lp", flash_standby, 1);
        reg_read(4'h3, rd); chk("R11", "stby bit cleared in lp", rd, 8'h00);
        lp_mode = 1'b0;
        #1 chk("R11", "standby after lp", flash_standby, 0);

        // R12 hardware clear beats write
        @(negedge clk);
        reg_addr = 4'h3; reg_wdata = 8'h01; reg_wr = 1'b1; irq_ack = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; irq_ack = 1'b0;
        #1 chk("R12", "standby after write+irq", flash_standby, 0);
        @(negedge clk);
        reg_addr = 4'h3; reg_wdata = 8'h01; reg_wr = 1'b1;
        mem_addr = 16'hB000; mem_rd = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; mem_rd = 1'b0;
        #1 chk("R12", "standby after write+flash access", flash_standby, 0);

        finish_run();
    end

endmodule